// File: doc/BRIEF.md
# Block-Oriented DMA Channel

This block is one DMA channel that copies 32-bit words from a source region to a destination region, or stores one constant word over a destination region. Software sets a base source address, a base destination address, a total word count, a block word count, a fill word and a control word through a small register-write port. A rising enable bit in the control word arms the channel. The working addresses and the remaining-word counter are loaded at that moment.

Each block is released by its own start event. The event is either the arming itself (immediate mode) or a pulse on the selected external request line. A block is moved as read/write pairs over a request/grant memory port. In fill mode only writes are issued. The channel can reload its working addresses at every block start. It can stay armed forever (repeat) or disarm itself when the total is exhausted, and it can raise an interrupt pulse when it disarms itself.

Top module: `blkdma_chan`

## Requirements
- R1: Writing the control register (select 5) with bit 31 set while it was clear copies the base source (select 0) and destination (select 1) into the working addresses and loads the remaining counter from the total length (select 2). A control write that finds bit 31 already set reloads none of them.
- R2: Control bits 11:10 set the destination step per word: 0 adds 4, 1 subtracts 4, 2 keeps the address, 3 adds 4. While a request waits for grant, its address and direction hold steady.
- R3: Control bits 14:13 set the source step: 0 adds 4, 1 subtracts 4, 2 keeps the address. Value 3 is fill mode, in which no read is issued and every write carries the fill register (select 4).
- R4: Control bits 28:24 give the start mode. Values 16 and above mean immediate: one block starts right after arming. A value m below 16 waits for a pulse on start_req[m], and pulses on other lines are ignored.
- R5: At block start the block counter loads the block length (select 3). A block length of 0 means 2^BLK_W words.
- R6: When the mode is not immediate and repeat (bit 29) is clear, the block is shortened to the words still remaining in the total.
- R7: Bit 12 reloads the working destination from its base at every block start, and bit 15 does the same for the source.
- R8: After a block, immediate mode clears bit 31. A non-repeat triggered mode clears it only once the remaining total reaches zero. Repeat mode leaves it set, and its blocks are not shortened.
- R9: When the channel clears bit 31 itself and bit 30 is set, irq is high for exactly one cycle. With bit 30 clear, irq stays low.
- R10: busy rises the cycle after a block start and falls after the grant of the block's last write. Start pulses that arrive while busy or while disarmed start nothing, and memory requests occur only while busy.
- R11: A triggered non-repeat block whose shortened length is zero makes no memory access. It clears bit 31 at once and signals irq as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 src, 1 dst, 2 total, 3 block, 4 fill, 5 control |
| cfg_wdata | input | 32 | Register write data |
| start_req | input | 16 | Start request lines, one per triggered mode |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with the grant of a read |
| armed | output | 1 | Current state of control bit 31 |
| busy | output | 1 | A block is being transferred |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with BLK_W=4, TOT_W=8 and ADDR_W=16. With these values a zero block length means 16 words, so the largest block fits in a short run, and both the immediate and the clamped zero-length cases can be checked in full. All sixteen pairs of source and destination step codes are swept against a word-by-word memory model, and the memory grant stalls every fourth cycle. Multi-block triggered runs cover the final clamped block, repeat mode with and without address reload, and start pulses on the wrong line, while busy, or while disarmed.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int          NUM_REQ  = 16;
    localparam logic [4:0]  MODE_NOW = 5'd16;

    typedef enum logic [1:0] {
        STEP_INC  = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_ALT  = 2'd3
    } step_e;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_TOT  = 3'd2,
        SEL_BLK  = 3'd3,
        SEL_FILL = 3'd4,
        SEL_CTRL = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;

    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic       rpt;
        logic [4:0] mode;
        logic       src_rld;
        step_e      src_step;
        logic       dst_rld;
        step_e      dst_step;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.en       = w[31];
        c.irq_en   = w[30];
        c.rpt      = w[29];
        c.mode     = (w[28:24] > MODE_NOW) ? MODE_NOW : w[28:24];
        c.src_rld  = w[15];
        c.src_step = step_e'(w[14:13]);
        c.dst_rld  = w[12];
        c.dst_step = step_e'(w[11:10]);
        return c;
    endfunction

    function automatic logic is_fill(input ctrl_t c);
        return c.src_step == STEP_ALT;
    endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TOT_W  = 32,
    parameter int BLK_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              clr_en,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [TOT_W-1:0]  tot_len,
    output logic [BLK_W-1:0]  blk_len,
    output logic [DATA_W-1:0] fill_word,
    output ctrl_t             ctrl,
    output logic              arm_pulse
);

    logic ctrl_wr;

    assign ctrl_wr   = cfg_we && (sel_e'(cfg_sel) == SEL_CTRL);
    assign arm_pulse = ctrl_wr && cfg_wdata[31] && !ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base  <= '0;
            dst_base  <= '0;
            tot_len   <= '0;
            blk_len   <= '0;
            fill_word <= '0;
            ctrl      <= '0;
        end else begin
            if (cfg_we) begin
                case (sel_e'(cfg_sel))
                    SEL_SRC:  src_base  <= cfg_wdata[ADDR_W-1:0];
                    SEL_DST:  dst_base  <= cfg_wdata[ADDR_W-1:0];
                    SEL_TOT:  tot_len   <= cfg_wdata[TOT_W-1:0];
                    SEL_BLK:  blk_len   <= cfg_wdata[BLK_W-1:0];
                    SEL_FILL: fill_word <= cfg_wdata[DATA_W-1:0];
                    SEL_CTRL: ctrl      <= decode_ctrl(cfg_wdata);
                    default: ;
                endcase
            end
            if (clr_en) ctrl.en <= 1'b0;
        end
    end

endmodule

// File: rtl/blkdma_addr.sv
module blkdma_addr
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter bit IS_SRC = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  step_e             step,
    input  logic              load,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] nxt;

    generate
        if (IS_SRC) begin : g_src
            always_comb begin
                case (step)
                    STEP_INC: nxt = cur + WORD_BYTES;
                    STEP_DEC: nxt = cur - WORD_BYTES;
                    default:  nxt = cur;
                endcase
            end
        end else begin : g_dst
            always_comb begin
                case (step)
                    STEP_DEC:  nxt = cur - WORD_BYTES;
                    STEP_HOLD: nxt = cur;
                    default:   nxt = cur + WORD_BYTES;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= base;
        else if (adv)  cur <= nxt;
    end

endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
    import blkdma_pkg::*;
#(
    parameter int TOT_W = 32,
    parameter int BLK_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               arm_pulse,
    input  logic [TOT_W-1:0]   tot_len,
    input  logic [BLK_W-1:0]   blk_len,
    input  logic [NUM_REQ-1:0] start_req,
    input  logic               mem_gnt,
    output phase_e             phase,
    output logic               blk_start,
    output logic               adv,
    output logic               clr_en,
    output logic               irq
);

    localparam int CNT_W = BLK_W + 1;
    localparam int WIDE  = (TOT_W > CNT_W) ? TOT_W : CNT_W;

    logic [CNT_W-1:0] blk_cnt;
    logic [TOT_W-1:0] tot_rem, tot_next;
    logic [WIDE-1:0]  full_w, tot_w, pick_w;
    logic             kick_q, imm, limit, go, zero_blk, wr_done, last, fin, fill;

    always_comb begin
        imm      = ctrl.mode == MODE_NOW;
        fill     = is_fill(ctrl);
        limit    = !imm && !ctrl.rpt;
        full_w   = (blk_len == '0) ? (WIDE'(1) << BLK_W) : WIDE'(blk_len);
        tot_w    = WIDE'(tot_rem);
        pick_w   = (limit && (full_w > tot_w)) ? tot_w : full_w;
        zero_blk = pick_w == '0;
        go       = (phase == PH_IDLE) && ctrl.en &&
                   (imm ? kick_q : start_req[ctrl.mode[3:0]]);
        wr_done  = (phase == PH_WR) && mem_gnt;
        last     = blk_cnt == CNT_W'(1);
        fin      = (wr_done && last) || (go && zero_blk);
        tot_next = wr_done ? (tot_rem - TOT_W'(1)) : tot_rem;
        clr_en   = fin && ctrl.en && (imm || (!ctrl.rpt && tot_next == '0));
    end

    assign blk_start = go && !zero_blk;
    assign adv       = wr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            blk_cnt <= '0;
            tot_rem <= '0;
            kick_q  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            kick_q <= arm_pulse;
            irq    <= clr_en && ctrl.irq_en;
            if (arm_pulse)    tot_rem <= tot_len;
            else if (wr_done) tot_rem <= tot_next;
            case (phase)
                PH_IDLE: if (blk_start) begin
                    blk_cnt <= CNT_W'(pick_w);
                    phase   <= fill ? PH_WR : PH_RD;
                end
                PH_RD: if (mem_gnt) phase <= PH_WR;
                PH_WR: if (mem_gnt) begin
                    blk_cnt <= blk_cnt - CNT_W'(1);
                    phase   <= last ? PH_IDLE : (fill ? PH_WR : PH_RD);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blkdma_chan.sv
module blkdma_chan
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TOT_W  = 32,
    parameter int BLK_W  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic [NUM_REQ-1:0] start_req,
    output logic               mem_req,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_gnt,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               armed,
    output logic               busy,
    output logic               irq
);

    logic [ADDR_W-1:0] src_base, dst_base, src_cur, dst_cur;
    logic [TOT_W-1:0]  tot_len;
    logic [BLK_W-1:0]  blk_len;
    logic [DATA_W-1:0] fill_word, rd_q;
    ctrl_t             ctrl;
    phase_e            phase;
    logic              arm_pulse, clr_en, blk_start, adv;

    blkdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOT_W(TOT_W), .BLK_W(BLK_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .clr_en(clr_en), .src_base(src_base), .dst_base(dst_base), .tot_len(tot_len),
        .blk_len(blk_len), .fill_word(fill_word), .ctrl(ctrl), .arm_pulse(arm_pulse)
    );

    blkdma_addr #(.ADDR_W(ADDR_W), .IS_SRC(1'b1)) u_src (
        .clk(clk), .rst(rst), .base(src_base), .step(ctrl.src_step),
        .load(arm_pulse || (blk_start && ctrl.src_rld)), .adv(adv), .cur(src_cur)
    );

    blkdma_addr #(.ADDR_W(ADDR_W), .IS_SRC(1'b0)) u_dst (
        .clk(clk), .rst(rst), .base(dst_base), .step(ctrl.dst_step),
        .load(arm_pulse || (blk_start && ctrl.dst_rld)), .adv(adv), .cur(dst_cur)
    );

    blkdma_seq #(.TOT_W(TOT_W), .BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .arm_pulse(arm_pulse), .tot_len(tot_len),
        .blk_len(blk_len), .start_req(start_req), .mem_gnt(mem_gnt), .phase(phase),
        .blk_start(blk_start), .adv(adv), .clr_en(clr_en), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst)                              rd_q <= '0;
        else if (phase == PH_RD && mem_gnt)   rd_q <= mem_rdata;
    end

    assign mem_req   = phase != PH_IDLE;
    assign mem_write = phase == PH_WR;
    assign mem_addr  = (phase == PH_WR) ? dst_cur : src_cur;
    assign mem_wdata = is_fill(ctrl) ? fill_word : rd_q;
    assign armed     = ctrl.en;
    assign busy      = phase != PH_IDLE;

endmodule

// File: rtl/blkdma_chan_chk.sv
module blkdma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              mem_req,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              armed,
    input logic              busy,
    input logic              irq,
    input logic              fill_mode
);

    // R9
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    irq_with_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!armed && $past(armed)));

    // R10
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R3
    fill_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && fill_mode) |-> mem_write);

    // R1
    arm_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(cfg_we));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

endmodule

bind blkdma_chan blkdma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .armed(armed), .busy(busy), .irq(irq),
    .fill_mode(ctrl.src_step == blkdma_pkg::STEP_ALT)
);

// File: tb/blkdma_chan_bench.sv
module blkdma_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int S_BASE = 'h100;
    localparam int D_BASE = 'h300;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] start_req = '0;
    logic mem_req, mem_write, mem_gnt, armed, busy, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic [31:0] expm [256];
    logic [1:0] stall_q = '0;
    int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkdma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOT_W(8), .BLK_W(4)) u_blkdma_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start_req(start_req), .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .armed(armed), .busy(busy), .irq(irq)
    );

    assign mem_gnt   = mem_req && (stall_q != 2'b11);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        stall_q <= stall_q + 2'd1;
        if (mem_req && mem_gnt) begin
            if (mem_write) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    function automatic logic [31:0] init_val(input int i);
        return 32'h5A000000 + 32'(i) * 32'h00010003;
    endfunction

    function automatic int step_of(input int st, input bit src);
        case (st)
            0: return 4;
            1: return -4;
            2: return 0;
            default: return src ? 0 : 4;
        endcase
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit ie, input bit rp,
                                            input int mode, input bit srl, input int ss,
                                            input bit drl, input int ds);
        return {en, ie, rp, 5'(mode), 8'h00, srl, 2'(ss), drl, 2'(ds), 10'h000};
    endfunction

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== expm[i]) begin
                if (bad == 0)
                    $display("memory word %0d: actual %h expected %h", i, mem[i], expm[i]);
                bad++;
            end
        end
        chk(req, "memory words differing", bad, 0);
    endtask

    task automatic model(input int s, input int d, input int ss, input int ds,
                         input int n, input logic [31:0] fv);
        int sa = s, da = d;
        for (int k = 0; k < n; k++) begin
            expm[da[9:2]] = (ss == 3) ? fv : expm[sa[9:2]];
            sa += step_of(ss, 1'b1);
            da += step_of(ds, 1'b0);
        end
    endtask

    task automatic wr_reg(input int sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        start_req[line] = 1'b1;
        @(negedge clk);
        start_req = '0;
    endtask

    task automatic idle_wait();
        int t = 0;
        repeat (3) @(negedge clk);
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input int tot, input int blk, input logic [31:0] fv);
        wr_reg(5, 32'h0);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            expm[i] = init_val(i);
        end
        wr_cnt = 0; rd_cnt = 0; irq_cnt = 0;
        wr_reg(0, S_BASE);
        wr_reg(1, D_BASE);
        wr_reg(2, 32'(tot));
        wr_reg(3, 32'(blk));
        wr_reg(4, fv);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R8", "armed after reset", armed, 0);
        chk("R10", "busy after reset", busy, 0);
        chk("R9", "irq after reset", irq, 0);
        chk("R10", "mem_req after reset", mem_req, 0);

        // R2 R3: sweep of every step pair, immediate mode
        for (int ss = 0; ss < 4; ss++) begin
            for (int ds = 0; ds < 4; ds++) begin
                logic [31:0] fv = 32'hF1110000 + 32'(ss * 4 + ds);
                setup(5, 5, fv);
                wr_reg(5, mk_ctrl(1, 1, 0, 16, 0, ss, 0, ds));
                idle_wait();
                model(S_BASE, D_BASE, ss, ds, 5, fv);
                chk_mem(ss == 3 ? "R3" : "R2");
                chk("R5", "words written", wr_cnt, 5);
                chk("R3", "reads issued", rd_cnt, (ss == 3) ? 0 : 5);
                chk("R8", "armed after immediate block", armed, 0);
                chk("R9", "irq cycles", irq_cnt, 1);
            end
        end

        // R4: mode above 16 acts as immediate
        setup(9, 3, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 31, 0, 0, 0, 0));
        idle_wait();
        chk("R4", "clamped mode words", wr_cnt, 3);
        chk("R4", "clamped mode armed", armed, 0);

        // R4 R6 R1: triggered multi-block run
        setup(10, 4, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 3, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R4", "words before any request", wr_cnt, 0);
        pulse(5);
        repeat (20) @(negedge clk);
        chk("R4", "words after wrong line", wr_cnt, 0);
        pulse(3);
        idle_wait();
        chk("R5", "first block words", wr_cnt, 4);
        chk("R8", "armed after first block", armed, 1);
        wr_reg(5, mk_ctrl(1, 1, 0, 3, 0, 0, 0, 0));
        pulse(3);
        idle_wait();
        chk("R8", "armed after second block", armed, 1);
        chk("R9", "irq before end", irq_cnt, 0);
        pulse(3);
        idle_wait();
        chk("R6", "words after clamped last block", wr_cnt, 10);
        chk("R8", "armed after total done", armed, 0);
        chk("R9", "irq after total done", irq_cnt, 1);
        model(S_BASE, D_BASE, 0, 0, 10, 0);
        chk_mem("R1");

        // R10: request while busy and while disarmed
        setup(20, 6, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 2, 0, 0, 0, 0));
        pulse(2);
        repeat (2) @(negedge clk);
        chk("R10", "busy during block", busy, 1);
        pulse(2);
        idle_wait();
        chk("R10", "words with pulse while busy", wr_cnt, 6);
        chk("R10", "busy after block", busy, 0);
        wr_reg(5, 32'h0);
        pulse(2);
        idle_wait();
        chk("R10", "words with pulse while disarmed", wr_cnt, 6);

        // R7 R8: repeat with per-block reload
        setup(3, 4, 0);
        wr_reg(5, mk_ctrl(1, 1, 1, 1, 1, 0, 1, 0));
        for (int b = 0; b < 3; b++) begin
            pulse(1);
            idle_wait();
        end
        chk("R8", "repeat words, no clamp", wr_cnt, 12);
        chk("R8", "repeat stays armed", armed, 1);
        chk("R9", "repeat irq", irq_cnt, 0);
        model(S_BASE, D_BASE, 0, 0, 4, 0);
        chk_mem("R7");

        // R8: repeat without reload keeps stepping
        setup(3, 4, 0);
        wr_reg(5, mk_ctrl(1, 0, 1, 1, 0, 0, 0, 0));
        pulse(1);
        idle_wait();
        pulse(1);
        idle_wait();
        chk("R8", "repeat words without reload", wr_cnt, 8);
        model(S_BASE, D_BASE, 0, 0, 8, 0);
        chk_mem("R7");

        // R5: zero block length in immediate mode
        setup(2, 0, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 16, 0, 0, 0, 0));
        idle_wait();
        chk("R5", "zero length immediate words", wr_cnt, 16);
        model(S_BASE, D_BASE, 0, 0, 16, 0);
        chk_mem("R5");

        // R6: zero block length clamped to total
        setup(5, 0, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 7, 0, 0, 0, 0));
        pulse(7);
        idle_wait();
        chk("R6", "zero length clamped words", wr_cnt, 5);
        chk("R6", "armed after clamped run", armed, 0);

        // R11: zero total, triggered
        setup(0, 4, 0);
        wr_reg(5, mk_ctrl(1, 1, 0, 4, 0, 0, 0, 0));
        pulse(4);
        repeat (6) @(negedge clk);
        chk("R11", "words with zero total", wr_cnt + rd_cnt, 0);
        chk("R11", "armed with zero total", armed, 0);
        chk("R11", "irq with zero total", irq_cnt, 1);

        // R9: interrupt disabled
        setup(3, 3, 0);
        wr_reg(5, mk_ctrl(1, 0, 0, 16, 0, 0, 0, 0));
        idle_wait();
        chk("R9", "irq with bit 30 clear", irq_cnt, 0);
        chk("R8", "armed with bit 30 clear", armed, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule